// File: doc/BRIEF.md
# Memory Response Ordering Buffer

This block sits between a compute pipeline and its global memory path. It records every outstanding load or store, gives each one a sequence tag, accepts completions that name those tags, and hands finished responses back to the pipeline one per cycle through a valid/ready handshake. It supports two delivery disciplines, chosen at run time. In program order, responses leave strictly in issue order, so a finished younger request waits behind an unfinished older one. In arrival order, finished loads and finished stores sit in two separate response queues, and the oldest completion across both queues leaves first.

The block also produces backpressure. It counts loads and stores in flight, and it derives ready flags for the request side and for each response queue from a configured queue size. The request-side flag also counts reservations the pipeline has promised but not yet issued. A completion that names an unknown or already finished tag sets a sticky error flag and has no other effect. A change of delivery mode takes effect only once nothing is in flight, and new issues are refused while such a change waits.

Top module: `mem_resp_orderer`

## Requirements
- R1: After reset, no response is offered, both in-flight counts are zero, the error flag is low, the delivery mode is program order (`mode_ooo_o` = 0), the first issue tag is 0, and with zero reservations every ready output is high.
- R2: Accepted issues receive consecutive tags from `iss_tag_o`, starting at 0 and wrapping modulo 2^(log2(DEPTH)+1).
- R3: In program order (`mode_ooo_o` = 0), responses are offered in issue order, and a response is offered only once its own completion has arrived. A completed younger entry waits behind an incomplete older one.
- R4: In arrival order (`mode_ooo_o` = 1), responses are offered in the order their completions arrived, across loads and stores. `rsp_is_load_o` is 1 for a load and 0 for a store.
- R5: While `rsp_valid_o` is high and `rsp_ready_i` is low, the offered response stays valid and its tag and kind do not change.
- R6: `ld_q_rdy_o` (`st_q_rdy_o`) is high exactly while fewer than QSIZE completed loads (stores) wait in the arrival-order response queue.
- R7: `req_rdy_o` is high exactly while loads in flight plus stores in flight plus `pend_res_i` is below QSIZE. `iss_ready_o` is never high while `req_rdy_o` is low.
- R8: `ld_inflight_o` and `st_inflight_o` rise by one on each accepted load or store issue and fall by one when that response is retired.
- R9: A completion whose tag is not in flight, or whose completion has already arrived, sets `err_o`. `err_o` stays set until reset, and that completion changes nothing else.
- R10: A new value on `mode_ooo_i` takes effect on `mode_ooo_o` one cycle after both in-flight counts reach zero. While the change waits, `iss_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ooo_i | input | 1 | Requested mode: 0 program order, 1 arrival order |
| pend_res_i | input | CNT_W | Reservations not yet issued |
| iss_valid_i | input | 1 | Issue request |
| iss_is_load_i | input | 1 | Issue is a load (1) or a store (0) |
| iss_ready_o | output | 1 | Issue accepted this cycle when valid |
| iss_tag_o | output | SEQ_W | Tag given to the issue |
| cmp_valid_i | input | 1 | Completion returns |
| cmp_tag_i | input | SEQ_W | Tag of the completion |
| rsp_valid_o | output | 1 | A response is offered |
| rsp_ready_i | input | 1 | Pipeline takes the response |
| rsp_tag_o | output | SEQ_W | Tag of the offered response |
| rsp_is_load_o | output | 1 | Offered response is a load |
| req_rdy_o | output | 1 | Request-side occupancy ready |
| ld_q_rdy_o | output | 1 | Load response queue write-ready |
| st_q_rdy_o | output | 1 | Store response queue write-ready |
| ld_inflight_o | output | CNT_W | Loads in flight |
| st_inflight_o | output | CNT_W | Stores in flight |
| mode_ooo_o | output | 1 | Delivery mode in force |
| err_o | output | 1 | Sticky bad-completion flag |

## Verification
In program order the bench completes a mix of loads and stores in reverse issue order. No response may appear until the oldest one finishes, which separates issue-order gating from arrival order. In arrival order it completes interleaved loads and stores in a scrambled order. The retire sequence must follow that order across both queues, which exposes a design that drains one queue before the other. Filling the load queue to its threshold, sweeping reservation counts, and completing one tag twice probe the ready boundaries and the error path. A mode change requested with one request outstanding shows the deferral.

// File: rtl/mro_pkg.sv
package mro_pkg;
    typedef enum logic {
        ORD_PROGRAM = 1'b0,
        ORD_ARRIVAL = 1'b1
    } ord_mode_e;
endpackage

// File: rtl/mro_resp_fifo.sv
module mro_resp_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [W-1:0]                 push_data_i,
    input  logic                         pop_i,
    output logic [W-1:0]                 head_o,
    output logic                         empty_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.mem[st_q.wr] = push_data_i;
            st_d.wr = (st_q.wr == PW'(DEPTH-1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop_i) begin
            st_d.rd = (st_q.rd == PW'(DEPTH-1)) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(push_i) - CW'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rd];
    assign empty_o = (st_q.cnt == '0);
    assign count_o = st_q.cnt;

    // R4: the queues hold every completion, never spill
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (st_q.cnt < CW'(DEPTH)));
    // R4: a pop always takes a real entry
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (st_q.cnt != '0));
endmodule

// File: rtl/mro_age_pick.sv
module mro_age_pick #(
    parameter int SW = 5
) (
    input  logic          a_valid_i,
    input  logic [SW-1:0] a_stamp_i,
    input  logic          b_valid_i,
    input  logic [SW-1:0] b_stamp_i,
    output logic          pick_b_o
);
    logic [SW-1:0] diff;
    // wrap-safe age compare: b older than a when b - a is negative
    assign diff     = b_stamp_i - a_stamp_i;
    assign pick_b_o = b_valid_i && (!a_valid_i || diff[SW-1]);
endmodule

// File: rtl/mem_resp_orderer.sv
module mem_resp_orderer
    import mro_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int QSIZE = 6,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int SEQ_W = IDX_W + 1,
    localparam int CNT_W = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ooo_i,
    input  logic [CNT_W-1:0] pend_res_i,
    input  logic             iss_valid_i,
    input  logic             iss_is_load_i,
    output logic             iss_ready_o,
    output logic [SEQ_W-1:0] iss_tag_o,
    input  logic             cmp_valid_i,
    input  logic [SEQ_W-1:0] cmp_tag_i,
    output logic             rsp_valid_o,
    input  logic             rsp_ready_i,
    output logic [SEQ_W-1:0] rsp_tag_o,
    output logic             rsp_is_load_o,
    output logic             req_rdy_o,
    output logic             ld_q_rdy_o,
    output logic             st_q_rdy_o,
    output logic [CNT_W-1:0] ld_inflight_o,
    output logic [CNT_W-1:0] st_inflight_o,
    output logic             mode_ooo_o,
    output logic             err_o
);
    localparam int SW = SEQ_W + 1;
    localparam int QW = SEQ_W + SW;

    typedef struct packed {
        ord_mode_e                   mode;
        logic [SEQ_W-1:0]            head;
        logic [SEQ_W-1:0]            tail;
        logic [DEPTH-1:0]            live;
        logic [DEPTH-1:0]            done;
        logic [DEPTH-1:0]            is_ld;
        logic [DEPTH-1:0][SEQ_W-1:0] tags;
        logic [SW-1:0]               stamp;
        logic [CNT_W-1:0]            n_ld;
        logic [CNT_W-1:0]            n_st;
        logic                        err;
    } trk_t;

    trk_t cur_q, nxt_d;

    logic [IDX_W-1:0] ti, hi, ci;
    logic             mode_hold, iss_fire, cmp_hit, retire, pick_st;
    logic [CNT_W:0]   occ;
    logic [1:0]       q_push, q_pop, q_empty;
    logic [QW-1:0]    q_push_data;
    logic [1:0][QW-1:0]    q_head;
    logic [1:0][CNT_W-1:0] q_cnt;

    assign ti        = cur_q.tail[IDX_W-1:0];
    assign hi        = cur_q.head[IDX_W-1:0];
    assign ci        = cmp_tag_i[IDX_W-1:0];
    assign mode_hold = (ord_mode_e'(mode_ooo_i) != cur_q.mode);
    assign occ       = {1'b0, cur_q.n_ld} + {1'b0, cur_q.n_st} + {1'b0, pend_res_i};
    assign req_rdy_o = (occ < (CNT_W+1)'(QSIZE));
    assign iss_ready_o = !mode_hold && !cur_q.live[ti] && req_rdy_o;
    assign iss_fire  = iss_valid_i && iss_ready_o;
    assign iss_tag_o = cur_q.tail;
    assign cmp_hit   = cmp_valid_i && cur_q.live[ci] && !cur_q.done[ci]
                       && (cur_q.tags[ci] == cmp_tag_i);

    // queue 0 holds loads, queue 1 holds stores
    for (genvar k = 0; k < 2; k++) begin : g_q
        mro_resp_fifo #(.DEPTH(DEPTH), .W(QW)) i_fifo (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_i      (q_push[k]),
            .push_data_i (q_push_data),
            .pop_i       (q_pop[k]),
            .head_o      (q_head[k]),
            .empty_o     (q_empty[k]),
            .count_o     (q_cnt[k])
        );
    end

    mro_age_pick #(.SW(SW)) i_pick (
        .a_valid_i (!q_empty[0]),
        .a_stamp_i (q_head[0][SW-1:0]),
        .b_valid_i (!q_empty[1]),
        .b_stamp_i (q_head[1][SW-1:0]),
        .pick_b_o  (pick_st)
    );

    always_comb begin
        nxt_d       = cur_q;
        q_push      = '0;
        q_pop       = '0;
        q_push_data = {cmp_tag_i, cur_q.stamp};

        if (cur_q.mode == ORD_PROGRAM) begin
            rsp_valid_o   = cur_q.live[hi] && cur_q.done[hi];
            rsp_tag_o     = cur_q.tags[hi];
            rsp_is_load_o = cur_q.is_ld[hi];
        end else begin
            rsp_valid_o   = !(&q_empty);
            rsp_is_load_o = !pick_st;
            rsp_tag_o     = pick_st ? q_head[1][QW-1:SW] : q_head[0][QW-1:SW];
        end
        retire = rsp_valid_o && rsp_ready_i;

        if (retire) begin
            if (cur_q.mode == ORD_PROGRAM) begin
                nxt_d.live[hi] = 1'b0;
                nxt_d.done[hi] = 1'b0;
                nxt_d.head     = cur_q.head + 1'b1;
            end else begin
                q_pop[pick_st] = 1'b1;
            end
        end

        if (cmp_hit) begin
            if (cur_q.mode == ORD_PROGRAM) begin
                nxt_d.done[ci] = 1'b1;
            end else begin
                nxt_d.live[ci] = 1'b0;
                q_push[cur_q.is_ld[ci] ? 0 : 1] = 1'b1;
                nxt_d.stamp = cur_q.stamp + 1'b1;
            end
        end else if (cmp_valid_i) begin
            nxt_d.err = 1'b1;
        end

        if (iss_fire) begin
            nxt_d.live[ti]  = 1'b1;
            nxt_d.done[ti]  = 1'b0;
            nxt_d.is_ld[ti] = iss_is_load_i;
            nxt_d.tags[ti]  = cur_q.tail;
            nxt_d.tail      = cur_q.tail + 1'b1;
        end

        nxt_d.n_ld = cur_q.n_ld + CNT_W'(iss_fire && iss_is_load_i)
                                - CNT_W'(retire && rsp_is_load_o);
        nxt_d.n_st = cur_q.n_st + CNT_W'(iss_fire && !iss_is_load_i)
                                - CNT_W'(retire && !rsp_is_load_o);

        if (mode_hold && cur_q.n_ld == '0 && cur_q.n_st == '0) begin
            nxt_d.mode = ord_mode_e'(mode_ooo_i);
            nxt_d.head = cur_q.tail;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ld_q_rdy_o    = (q_cnt[0] < CNT_W'(QSIZE));
    assign st_q_rdy_o    = (q_cnt[1] < CNT_W'(QSIZE));
    assign ld_inflight_o = cur_q.n_ld;
    assign st_inflight_o = cur_q.n_st;
    assign mode_ooo_o    = (cur_q.mode == ORD_ARRIVAL);
    assign err_o         = cur_q.err;

    assert_mode_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ooo_o != $past(mode_ooo_o)) |->
            ($past(ld_inflight_o) == '0 && $past(st_inflight_o) == '0));
    assert_hold_blocks_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ooo_i != mode_ooo_o) |-> !iss_ready_o);
    assert_rsp_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_ready_i) |=>
            (rsp_valid_o && $stable(rsp_tag_o) && $stable(rsp_is_load_o)));
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    assert_inflight_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, ld_inflight_o} + {1'b0, st_inflight_o}) <= (CNT_W+1)'(DEPTH));
    assert_issue_needs_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_ready_o |-> req_rdy_o);
endmodule

// File: tb/test_mem_resp_orderer.sv
module test_mem_resp_orderer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int QSIZE = 6;
    localparam int SEQ_W = 4;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_ooo_i = 1'b0;
    logic [CNT_W-1:0] pend_res_i = '0;
    logic             iss_valid_i = 1'b0;
    logic             iss_is_load_i = 1'b0;
    logic             iss_ready_o;
    logic [SEQ_W-1:0] iss_tag_o;
    logic             cmp_valid_i = 1'b0;
    logic [SEQ_W-1:0] cmp_tag_i = '0;
    logic             rsp_valid_o;
    logic             rsp_ready_i = 1'b0;
    logic [SEQ_W-1:0] rsp_tag_o;
    logic             rsp_is_load_o;
    logic             req_rdy_o, ld_q_rdy_o, st_q_rdy_o;
    logic [CNT_W-1:0] ld_inflight_o, st_inflight_o;
    logic             mode_ooo_o, err_o;

    int checks = 0;
    int errors = 0;
    logic [SEQ_W-1:0] exp_tag = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_resp_orderer #(.DEPTH(DEPTH), .QSIZE(QSIZE)) i_mem_resp_orderer (
        .clk(clk), .rst_n(rst_n), .mode_ooo_i(mode_ooo_i), .pend_res_i(pend_res_i),
        .iss_valid_i(iss_valid_i), .iss_is_load_i(iss_is_load_i),
        .iss_ready_o(iss_ready_o), .iss_tag_o(iss_tag_o),
        .cmp_valid_i(cmp_valid_i), .cmp_tag_i(cmp_tag_i),
        .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
        .rsp_tag_o(rsp_tag_o), .rsp_is_load_o(rsp_is_load_o),
        .req_rdy_o(req_rdy_o), .ld_q_rdy_o(ld_q_rdy_o), .st_q_rdy_o(st_q_rdy_o),
        .ld_inflight_o(ld_inflight_o), .st_inflight_o(st_inflight_o),
        .mode_ooo_o(mode_ooo_o), .err_o(err_o)
    );

    // pending reservations -> expected request-side ready, zero in flight (R7)
    localparam logic [4:0] R7_VEC [6] = '{
        {4'd0, 1'b1}, {4'd1, 1'b1}, {4'd5, 1'b1},
        {4'd6, 1'b0}, {4'd7, 1'b0}, {4'd15, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_issue(input bit ld, output logic [SEQ_W-1:0] tg);
        iss_valid_i = 1'b1;
        iss_is_load_i = ld;
        #1;
        tg = iss_tag_o;
        chk("R2 issue accepted", int'(iss_ready_o), 1);
        chk("R2 issue tag", int'(iss_tag_o), int'(exp_tag));
        exp_tag = exp_tag + 1'b1;
        @(negedge clk);
        iss_valid_i = 1'b0;
    endtask

    task automatic do_cmp(input logic [SEQ_W-1:0] tg);
        cmp_valid_i = 1'b1;
        cmp_tag_i = tg;
        @(negedge clk);
        cmp_valid_i = 1'b0;
    endtask

    task automatic do_retire(input string req, input logic [SEQ_W-1:0] tg, input bit ld);
        #1;
        chk({req, " rsp valid"}, int'(rsp_valid_o), 1);
        chk({req, " rsp tag"}, int'(rsp_tag_o), int'(tg));
        chk({req, " rsp kind"}, int'(rsp_is_load_o), int'(ld));
        rsp_ready_i = 1'b1;
        @(negedge clk);
        rsp_ready_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [SEQ_W-1:0] t0, t1, t2, t3;
        logic [SEQ_W-1:0] lt [QSIZE];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 rsp_valid", int'(rsp_valid_o), 0);
        chk("R1 ld count", int'(ld_inflight_o), 0);
        chk("R1 st count", int'(st_inflight_o), 0);
        chk("R1 err", int'(err_o), 0);
        chk("R1 mode", int'(mode_ooo_o), 0);
        chk("R1 tag", int'(iss_tag_o), 0);
        chk("R1 ready", int'({req_rdy_o, ld_q_rdy_o, st_q_rdy_o, iss_ready_o}), 15);
        @(negedge clk);

        // R7 vector sweep
        foreach (R7_VEC[i]) begin
            pend_res_i = R7_VEC[i][4:1];
            #1;
            chk("R7 req_rdy", int'(req_rdy_o), int'(R7_VEC[i][0]));
            chk("R7 iss_ready", int'(iss_ready_o), int'(R7_VEC[i][0]));
            @(negedge clk);
        end
        pend_res_i = '0;

        // R3 program order with reverse completions
        do_issue(1'b1, t0);
        do_issue(1'b0, t1);
        do_issue(1'b1, t2);
        chk("R8 ld count", int'(ld_inflight_o), 2);
        chk("R8 st count", int'(st_inflight_o), 1);
        pend_res_i = 4'd3;
        #1 chk("R7 occupancy with reservations", int'(req_rdy_o), 0);
        pend_res_i = 4'd2;
        #1 chk("R7 occupancy below size", int'(req_rdy_o), 1);
        pend_res_i = '0;
        @(negedge clk);
        do_cmp(t2);
        do_cmp(t1);
        #1 chk("R3 younger waits", int'(rsp_valid_o), 0);
        @(negedge clk);
        do_cmp(t0);
        do_retire("R3", t0, 1'b1);
        do_retire("R3", t1, 1'b0);
        do_retire("R3", t2, 1'b1);
        #1;
        chk("R8 ld drained", int'(ld_inflight_o), 0);
        chk("R8 st drained", int'(st_inflight_o), 0);
        chk("R3 empty", int'(rsp_valid_o), 0);
        @(negedge clk);

        // R5 hold under backpressure, R9 duplicate completion
        do_issue(1'b0, t0);
        do_cmp(t0);
        repeat (3) begin
            #1;
            chk("R5 held valid", int'(rsp_valid_o), 1);
            chk("R5 held tag", int'(rsp_tag_o), int'(t0));
            @(negedge clk);
        end
        do_cmp(t0);
        #1;
        chk("R9 err set", int'(err_o), 1);
        chk("R9 st count unchanged", int'(st_inflight_o), 1);
        @(negedge clk);
        do_retire("R9", t0, 1'b0);
        do_cmp(t0);
        #1;
        chk("R9 stale no rsp", int'(rsp_valid_o), 0);
        chk("R9 err sticky", int'(err_o), 1);
        @(negedge clk);

        // R10 deferred mode change
        do_issue(1'b1, t0);
        mode_ooo_i = 1'b1;
        #1;
        chk("R10 issue blocked", int'(iss_ready_o), 0);
        chk("R10 mode held", int'(mode_ooo_o), 0);
        @(negedge clk);
        do_cmp(t0);
        do_retire("R10", t0, 1'b1);
        #1 chk("R10 not yet", int'(mode_ooo_o), 0);
        @(negedge clk);
        #1;
        chk("R10 mode switched", int'(mode_ooo_o), 1);
        chk("R10 issue reopened", int'(iss_ready_o), 1);
        @(negedge clk);

        // R4 arrival order across queues
        do_issue(1'b1, t0);
        do_issue(1'b0, t1);
        do_issue(1'b1, t2);
        do_issue(1'b0, t3);
        do_cmp(t3);
        do_cmp(t0);
        do_cmp(t2);
        do_cmp(t1);
        do_retire("R4", t3, 1'b0);
        do_retire("R4", t0, 1'b1);
        do_retire("R4", t2, 1'b1);
        do_retire("R4", t1, 1'b0);

        // R6 load queue threshold
        for (int i = 0; i < QSIZE; i++) do_issue(1'b1, lt[i]);
        #1 chk("R7 full occupancy", int'(req_rdy_o), 0);
        @(negedge clk);
        for (int i = 0; i < QSIZE - 1; i++) do_cmp(lt[i]);
        #1 chk("R6 below size", int'(ld_q_rdy_o), 1);
        @(negedge clk);
        do_cmp(lt[QSIZE-1]);
        #1;
        chk("R6 at size", int'(ld_q_rdy_o), 0);
        chk("R6 store queue free", int'(st_q_rdy_o), 1);
        @(negedge clk);
        do_retire("R6", lt[0], 1'b1);
        #1 chk("R6 after pop", int'(ld_q_rdy_o), 1);
        @(negedge clk);
        for (int i = 1; i < QSIZE; i++) do_retire("R4", lt[i], 1'b1);
        #1;
        chk("R8 final ld", int'(ld_inflight_o), 0);
        chk("R8 final st", int'(st_inflight_o), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule